// File: doc/BRIEF.md
# DMA Interrupt Control and Status Register

This block holds the 32-bit interrupt control and status word shared by seven DMA channels. Software writes it to choose which channels may raise an interrupt, to turn the whole group on or off, and to force an error interrupt. Each channel engine sends a one-cycle completion pulse. When the channel's enable is set, that pulse latches a per-channel flag. Software acknowledges a flag by writing a 1 to its bit.

A master bit summarises the word. It is set when the global enable is on and at least one flag is pending, or when the forced bus-error bit is on. The block drives one interrupt request line toward the system interrupt controller, where it is wired to input 3. That request is a one-cycle pulse, issued only when the master bit changes from 0 to 1. A master bit that is already set therefore produces no new request until software has first cleared it.

Top module: `dma_irq_ctrl`

## Requirements
- R1: After reset the read word is all zeros and `irq_pulse` is low.
- R2: A write loads bits 0-5, bit 15 (forced bus error) and bits 16-23 from the write data, with bit 16+n the enable of channel n and bit 23 the global enable. Bits 6-14 always read 0.
- R3: On a write, a 1 in bit 24+n clears the flag of channel n, and a 0 leaves it unchanged.
- R4: A `dma_done[n]` pulse sets flag bit 24+n when enable bit 16+n is set in the word as it stood before that clock edge.
- R5: A `dma_done[n]` pulse while enable bit 16+n is 0 leaves flag bit 24+n unchanged.
- R6: After a write, bit 31 equals (bit 23 AND any of bits 24-30) OR bit 15, evaluated on the updated word.
- R7: After a completion pulse sets a flag, bit 31 is re-evaluated by the same rule as in R6.
- R8: `irq_pulse` is high for exactly the one cycle in which bit 31 first reads 1 after reading 0. It stays low while bit 31 remains set.
- R9: When a write clears a flag in the same cycle that an enabled completion pulse sets it, the set wins and the flag reads 1.
- R10: In a cycle with no write and no enabled completion pulse, the whole word holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 32 | Write data |
| dma_done | input | 7 | One-cycle completion pulse per channel |
| rd_data | output | 32 | Registered read word |
| irq_pulse | output | 1 | One-cycle request to interrupt controller input 3 |

## Verification
The write-1-to-clear acknowledge and the completion-driven flag set can land on the same flag in the same clock. The random stimulus makes this happen by overlapping write strobes that carry random clear masks with random completion pulses. A directed case also clears and completes channel 1 in one cycle. In both cases the result is judged against a bench model in which the set takes priority, and the master bit and request pulse are then checked against the updated word.

// File: rtl/dma_irq_pkg.sv
package dma_irq_pkg;
  parameter int NUM_CH  = 7;
  parameter int LOW_W   = 6;
  parameter int WORD_W  = 32;

  localparam int BERR_BIT = 15;
  localparam int EN_LSB   = 16;
  localparam int GE_BIT   = EN_LSB + NUM_CH;
  localparam int FLG_LSB  = GE_BIT + 1;
  localparam int MST_BIT  = FLG_LSB + NUM_CH;

  typedef struct packed {
    logic              ge;
    logic [NUM_CH-1:0] en;
    logic              berr;
    logic [LOW_W-1:0]  low;
  } ctl_t;
endpackage

// File: rtl/dma_irq_ctl_fields.sv
module dma_irq_ctl_fields
  import dma_irq_pkg::*;
#(
  parameter int W = WORD_W
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         wr_en,
  input  logic [W-1:0] wr_data,
  output ctl_t         ctl_q,
  output ctl_t         ctl_next
);
  always_comb begin
    ctl_next = ctl_q;
    if (wr_en) begin
      ctl_next.low  = wr_data[LOW_W-1:0];
      ctl_next.berr = wr_data[BERR_BIT];
      ctl_next.en   = wr_data[EN_LSB +: NUM_CH];
      ctl_next.ge   = wr_data[GE_BIT];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) ctl_q <= '0;
    else     ctl_q <= ctl_next;
  end
endmodule

// File: rtl/dma_irq_flag_bank.sv
module dma_irq_flag_bank #(
  parameter int N = 7
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         wr_en,
  input  logic [N-1:0] clr_mask,
  input  logic [N-1:0] done,
  input  logic [N-1:0] en,
  output logic [N-1:0] flag_q,
  output logic [N-1:0] flag_next,
  output logic         any_set
);
  logic [N-1:0] hit;

  for (genvar n = 0; n < N; n++) begin : g_ch
    assign hit[n] = done[n] & en[n];
    always_comb begin
      if (hit[n])                    flag_next[n] = 1'b1;
      else if (wr_en && clr_mask[n]) flag_next[n] = 1'b0;
      else                           flag_next[n] = flag_q[n];
    end
    always_ff @(posedge clk) begin
      if (rst) flag_q[n] <= 1'b0;
      else     flag_q[n] <= flag_next[n];
    end
  end

  assign any_set = |hit;
endmodule

// File: rtl/dma_irq_master.sv
module dma_irq_master #(
  parameter int N = 7
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         update,
  input  logic         ge_next,
  input  logic         berr_next,
  input  logic [N-1:0] flag_next,
  output logic         mst_q,
  output logic         irq_q
);
  logic mst_next;

  always_comb begin
    if (update) mst_next = (ge_next & (|flag_next)) | berr_next;
    else        mst_next = mst_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mst_q <= 1'b0;
      irq_q <= 1'b0;
    end else begin
      mst_q <= mst_next;
      irq_q <= mst_next & ~mst_q;
    end
  end
endmodule

// File: rtl/dma_irq_ctrl.sv
module dma_irq_ctrl
  import dma_irq_pkg::*;
#(
  parameter int W = WORD_W,
  parameter int N = NUM_CH
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         wr_en,
  input  logic [W-1:0] wr_data,
  input  logic [N-1:0] dma_done,
  output logic [W-1:0] rd_data,
  output logic         irq_pulse
);
  ctl_t         ctl_q, ctl_next;
  logic [N-1:0] flag_q, flag_next;
  logic         any_set, mst_q, irq_q;

  dma_irq_ctl_fields #(.W(W)) u_ctl (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
    .ctl_q(ctl_q), .ctl_next(ctl_next)
  );

  dma_irq_flag_bank #(.N(N)) u_flags (
    .clk(clk), .rst(rst), .wr_en(wr_en),
    .clr_mask(wr_data[FLG_LSB +: N]), .done(dma_done), .en(ctl_q.en),
    .flag_q(flag_q), .flag_next(flag_next), .any_set(any_set)
  );

  dma_irq_master #(.N(N)) u_mst (
    .clk(clk), .rst(rst), .update(wr_en | any_set),
    .ge_next(ctl_next.ge), .berr_next(ctl_next.berr), .flag_next(flag_next),
    .mst_q(mst_q), .irq_q(irq_q)
  );

  always_comb begin
    rd_data                   = '0;
    rd_data[LOW_W-1:0]        = ctl_q.low;
    rd_data[BERR_BIT]         = ctl_q.berr;
    rd_data[EN_LSB +: N]      = ctl_q.en;
    rd_data[GE_BIT]           = ctl_q.ge;
    rd_data[FLG_LSB +: N]     = flag_q;
    rd_data[MST_BIT]          = mst_q;
  end

  assign irq_pulse = irq_q;
endmodule

// File: rtl/dma_irq_ctrl_chk.sv
module dma_irq_ctrl_chk (
  input logic        clk,
  input logic        rst,
  input logic        wr_en,
  input logic [31:0] wr_data,
  input logic [6:0]  dma_done,
  input logic [31:0] rd_data,
  input logic        irq_pulse
);
  logic [6:0] acc;
  assign acc = dma_done & rd_data[22:16];

  assert_write_fields_R2: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> (rd_data[23:0] == ($past(wr_data[23:0]) & 24'hFF803F)));

  assert_ack_clear_R3: assert property (@(posedge clk) disable iff (rst)
    (wr_en && dma_done == 7'd0) |=>
      (rd_data[30:24] == ($past(rd_data[30:24]) & ~$past(wr_data[30:24]))));

  // R4 and R9: an enabled completion always leaves its flag set
  assert_done_sets_R4: assert property (@(posedge clk) disable iff (rst)
    (|acc) |=> ((rd_data[30:24] & $past(acc)) == $past(acc)));

  assert_disabled_hold_R5: assert property (@(posedge clk) disable iff (rst)
    !wr_en |=> ((rd_data[30:24] & ~$past(rd_data[22:16])) ==
                ($past(rd_data[30:24]) & ~$past(rd_data[22:16]))));

  // R6 and R7: master rule after a write or an accepted completion
  assert_master_rule_R6: assert property (@(posedge clk) disable iff (rst)
    (wr_en || (|acc)) |=>
      (rd_data[31] == ((rd_data[23] && (|rd_data[30:24])) || rd_data[15])));

  assert_irq_on_rise_R8: assert property (@(posedge clk) disable iff (rst)
    irq_pulse |-> (rd_data[31] && !$past(rd_data[31])));

  assert_irq_single_R8: assert property (@(posedge clk) disable iff (rst)
    irq_pulse |=> !irq_pulse);

  assert_idle_hold_R10: assert property (@(posedge clk) disable iff (rst)
    (!wr_en && acc == 7'd0) |=> $stable(rd_data));
endmodule

bind dma_irq_ctrl dma_irq_ctrl_chk u_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
  .dma_done(dma_done), .rd_data(rd_data), .irq_pulse(irq_pulse)
);

// File: tb/tb_dma_irq_ctrl.sv
`timescale 1ns/1ps
module tb_dma_irq_ctrl;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic [6:0]  dma_done = '0;
  logic [31:0] rd_data;
  logic        irq_pulse;

  int checks = 0;
  int fails  = 0;
  bit ended  = 0;
  logic [31:0] mreg = '0;

  always #4 clk = ~clk;

  dma_irq_ctrl dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
    .dma_done(dma_done), .rd_data(rd_data), .irq_pulse(irq_pulse)
  );

  function automatic logic [32:0] model(logic [31:0] r, logic wr,
                                        logic [31:0] wd, logic [6:0] dn);
    logic [31:0] n;
    logic [6:0]  a;
    n = r;
    a = dn & r[22:16];
    if (wr) begin
      n[23:0]  = wd[23:0] & 24'hFF803F;
      n[30:24] = r[30:24] & ~wd[30:24];
    end
    n[30:24] = n[30:24] | a;
    if (wr || (|a)) n[31] = (n[23] && (|n[30:24])) || n[15];
    return {n[31] & ~r[31], n};
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
    end
  endtask

  task automatic step(logic wr, logic [31:0] wd, logic [6:0] dn, string tag);
    logic [32:0] m;
    logic [6:0]  a;
    a = dn & mreg[22:16];
    m = model(mreg, wr, wd, dn);
    wr_en = wr; wr_data = wd; dma_done = dn;
    @(negedge clk);
    wr_en = 1'b0; dma_done = '0;
    if (tag != "") chk(tag, rd_data, m[31:0]);
    else begin
      chk("R2", {8'h0, rd_data[23:0]}, {8'h0, m[23:0]});
      chk((|a) ? "R4" : (wr ? "R3" : "R10"), {25'h0, rd_data[30:24]}, {25'h0, m[30:24]});
      chk(wr ? "R6" : "R7", {31'h0, rd_data[31]}, {31'h0, m[31]});
    end
    chk("R8", {31'h0, irq_pulse}, {31'h0, m[32]});
    mreg = m[31:0];
  endtask

  initial begin
    void'($urandom(32'h5EED_0042));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1", rd_data, 32'h0);
    chk("R1", {31'h0, irq_pulse}, 32'h0);

    step(1'b1, 32'h00FF_0000, 7'h00, "R2");       // enables + global enable
    step(1'b0, 32'h0,         7'h04, "R7");       // ch2 -> master rises
    step(1'b0, 32'h0,         7'h08, "R8");       // master already set, no pulse
    step(1'b1, 32'h7C80_7FFF, 7'h00, "R3");       // ack all, bits 6-14 read 0
    step(1'b1, 32'h0080_0000, 7'h00, "R6");       // global only, channels off
    step(1'b0, 32'h0,         7'h7F, "R5");       // disabled channels ignored
    step(1'b0, 32'h0,         7'h00, "R10");
    step(1'b1, 32'h0082_0000, 7'h00, "R2");       // ch1 enabled
    step(1'b0, 32'h0,         7'h02, "R4");
    step(1'b1, 32'h0282_0000, 7'h02, "R9");       // clear and set collide
    step(1'b1, 32'h7F00_8000, 7'h00, "R6");       // forced bus error
    step(1'b1, 32'h0000_0000, 7'h00, "R6");
    step(1'b1, 32'h0000_8000, 7'h00, "R8");       // rises again

    for (int i = 0; i < 3000; i++) begin
      logic        wr;
      logic [31:0] wd;
      logic [6:0]  dn;
      wr = ($urandom_range(3) == 0);
      wd = $urandom;
      if ($urandom_range(3) != 0) wd[15] = 1'b0;
      dn = ($urandom_range(2) == 0) ? 7'($urandom) : 7'h00;
      step(wr, wd, dn, "");
    end

    ended = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #1_000_000;
    if (!ended) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule